// File: doc/BRIEF.md
# 16-bit Load-Store Processor Core

This block is a multicycle 16-bit processor core. It holds eight general-purpose registers, a program counter and a three-bit condition register in which exactly one of negative, zero or positive is set. It fetches one 16-bit instruction at a time from a word-addressed memory through a single synchronous port. It then decodes the instruction and runs it through a short sequence of states: fetch, decode, execute, an optional pointer read, and an optional load write-back. The memory port carries at most one access per cycle. Read data returns in the cycle after the address is presented.

The instruction set uses a fixed 4-bit opcode in bits 15:12. It covers register and immediate arithmetic and logic, branches on the condition register, register jumps and subroutine calls, and three addressing styles for loads and stores: relative to the PC, indirect through a pointer word, and base register plus offset. A trap instruction passes its 8-bit vector to an external service unit through a request/done handshake. Opcodes the core does not implement stop it and raise a sticky flag.

A retire port pulses once per finished instruction. It reports the new PC, the condition register and any register write, so that an enclosing system can trace execution.

Top module: `lsc16_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, pc_o is 0x3000, cc_o is 3'b010 (Z), illegal_o, commit_o and trap_req_o are low, and the port presents a read of address 0x3000.
- R2: Opcode 1 adds and opcode 5 ANDs. Both take the first source from bits 8:6 and write the register in bits 11:9. Bit 5 set selects the sign-extended immediate in bits 4:0 as the second operand; bit 5 clear selects the register in bits 2:0. Opcode 9 writes the bitwise inverse of the bits 8:6 register.
- R3: cc_o encodes N, Z and P as bits 2, 1 and 0. After opcodes 1, 5, 9, 2, 10, 6 and 14 it holds exactly one bit, chosen by the sign of the value written. Stores, branches, jumps, calls and traps leave it unchanged.
- R4: Opcode 0 branches when at least one of instruction bits 11, 10 and 9 is set together with the held N, Z or P bit respectively. The target is the incremented PC plus the sign-extended bits 8:0; otherwise execution falls through.
- R5: Opcode 4 saves the incremented PC in R7. When bit 11 is set it jumps to the incremented PC plus the sign-extended bits 10:0; when bit 11 is clear it jumps to the register in bits 8:6. Opcode 12 jumps to the register in bits 8:6.
- R6: Opcodes 2 (load), 3 (store, data from bits 11:9) and 14 (address into bits 11:9) use the incremented PC plus the sign-extended bits 8:0.
- R7: Opcodes 6 (load) and 7 (store) address the register in bits 8:6 plus the sign-extended bits 5:0.
- R8: Opcodes 10 and 11 first read a pointer from the incremented PC plus the sign-extended bits 8:0. They then load from, or store to, that pointer, using two memory accesses.
- R9: Opcode 15 raises trap_req_o with bits 7:0 on trap_vec_o. Both hold until trap_done_i is sampled high, which is allowed in the first request cycle. Execution then resumes at the incremented PC, with no register write.
- R10: Opcodes 8 and 13 set illegal_o, which stays high until reset. From then on no memory access and no retire occur.
- R11: commit_o is high for one cycle after each instruction ends. In that cycle pc_o and cc_o hold the new state, and commit_we_o, commit_rd_o and commit_data_o report the register write. Retires are 3 cycles apart for register, branch, jump, call and direct store instructions; 4 for opcodes 2, 6 and 11; and 5 for opcode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_en_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read |
| trap_req_o | output | 1 | Trap service requested |
| trap_vec_o | output | 8 | Trap vector |
| trap_done_i | input | 1 | Trap service finished |
| illegal_o | output | 1 | Sticky unsupported-opcode halt |
| commit_o | output | 1 | One instruction retired |
| commit_we_o | output | 1 | Retired instruction wrote a register |
| commit_rd_o | output | 3 | Register written |
| commit_data_o | output | 16 | Value written |
| pc_o | output | 16 | Program counter |
| cc_o | output | 3 | Condition register {N,Z,P} |

## Verification
Two events can land on the same edge: a trap request and its completion. If the service unit answers in the very first request cycle, the core must retire the trap and fetch the next word at once. If the answer is late, the request and vector must hold steady. The bench answers one trap vector with zero latency and another after three cycles. At every retire it compares the PC, the condition register and the register write against a behavioural instruction-level model, and it checks the spacing between retires. A second overlap is the call through R7 while R7 itself is overwritten with the return address. The program calls through a base register and returns through R7, and the model computes the target before the link write.

// File: rtl/lsc16_pkg.sv
package lsc16_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [3:0] {
    OP_BR, OP_ADD, OP_LD, OP_ST, OP_JSR, OP_AND, OP_LDR, OP_STR,
    OP_RTI, OP_NOT, OP_LDI, OP_STI, OP_JMP, OP_RSV, OP_LEA, OP_TRAP
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_IND, ST_LDWB, ST_TRAP, ST_HALT
  } state_e;

  typedef enum logic [1:0] {ADDR_PC, ADDR_EA, ADDR_PTR} addr_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_PC, WB_EA} wb_sel_e;
  typedef enum logic [1:0] {PCS_REL, PCS_CALL, PCS_REG} pc_src_e;

  typedef struct packed {
    logic      mem_en;
    logic      mem_we;
    addr_sel_e addr_sel;
    logic      ir_load;
    logic      pc_inc;
    logic      pc_load;
    pc_src_e   pc_src;
    logic      rf_we;
    logic      wb_link;
    wb_sel_e   wb_sel;
    logic      cc_we;
    logic      commit;
    logic      trap_req;
  } ctrl_t;

  localparam logic [2:0] CC_N = 3'b100;
  localparam logic [2:0] CC_Z = 3'b010;
  localparam logic [2:0] CC_P = 3'b001;
endpackage

// File: rtl/lsc16_regfile.sv
module lsc16_regfile
  import lsc16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_a_i,
  input  logic [IDX_W-1:0]  raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int FLAT_W = NUM_REGS * DATA_W;

  logic [FLAT_W-1:0] flat;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                q <= '0;
        else if (we_i && waddr_i == IDX_W'(g))      q <= wdata_i;
      end
      assign flat[g*DATA_W +: DATA_W] = q;
    end
  endgenerate

  assign rdata_a_o = flat[int'(raddr_a_i)*DATA_W +: DATA_W];
  assign rdata_b_o = flat[int'(raddr_b_i)*DATA_W +: DATA_W];
endmodule

// File: rtl/lsc16_alu.sv
module lsc16_alu
  import lsc16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_NOT:  y_o = ~a_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/lsc16_agu.sv
module lsc16_agu
  import lsc16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] ir_i,
  input  logic [DATA_W-1:0] base_i,
  output logic [DATA_W-1:0] ea_o,
  output logic [DATA_W-1:0] rel_o,
  output logic [DATA_W-1:0] call_o
);
  localparam int OP_MSB = DATA_W - 1;

  logic [DATA_W-1:0] off9, off6, off11;
  opcode_e op;

  assign off9  = {{(DATA_W-9){ir_i[8]}},   ir_i[8:0]};
  assign off6  = {{(DATA_W-6){ir_i[5]}},   ir_i[5:0]};
  assign off11 = {{(DATA_W-11){ir_i[10]}}, ir_i[10:0]};
  assign op    = opcode_e'(ir_i[OP_MSB -: 4]);

  assign rel_o  = pc_i + off9;
  assign ea_o   = (op == OP_LDR || op == OP_STR) ? base_i + off6 : rel_o;
  // bit 11 picks the offset call; clear uses the base register
  assign call_o = ir_i[11] ? pc_i + off11 : base_i;
endmodule

// File: rtl/lsc16_ctrl.sv
module lsc16_ctrl
  import lsc16_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  opcode_e op_i,
  input  logic [2:0] nzp_i,
  input  logic [2:0] cc_i,
  input  logic    trap_done_i,
  output ctrl_t   ctrl_o,
  output state_e  state_o
);
  state_e state_q, state_d;
  logic   br_take;

  assign br_take = |(nzp_i & cc_i);

  always_comb begin
    ctrl_o  = '0;
    state_d = state_q;
    case (state_q)
      ST_FETCH: begin
        ctrl_o.mem_en   = 1'b1;
        ctrl_o.addr_sel = ADDR_PC;
        ctrl_o.pc_inc   = 1'b1;
        state_d         = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl_o.ir_load = 1'b1;
        state_d        = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        case (op_i)
          OP_ADD, OP_AND, OP_NOT, OP_LEA: begin
            ctrl_o.rf_we  = 1'b1;
            ctrl_o.wb_sel = (op_i == OP_LEA) ? WB_EA : WB_ALU;
            ctrl_o.cc_we  = 1'b1;
            ctrl_o.commit = 1'b1;
          end
          OP_BR: begin
            ctrl_o.pc_load = br_take;
            ctrl_o.pc_src  = PCS_REL;
            ctrl_o.commit  = 1'b1;
          end
          OP_JMP: begin
            ctrl_o.pc_load = 1'b1;
            ctrl_o.pc_src  = PCS_REG;
            ctrl_o.commit  = 1'b1;
          end
          OP_JSR: begin
            ctrl_o.rf_we   = 1'b1;
            ctrl_o.wb_link = 1'b1;
            ctrl_o.wb_sel  = WB_PC;
            ctrl_o.pc_load = 1'b1;
            ctrl_o.pc_src  = PCS_CALL;
            ctrl_o.commit  = 1'b1;
          end
          OP_LD, OP_LDR: begin
            ctrl_o.mem_en   = 1'b1;
            ctrl_o.addr_sel = ADDR_EA;
            state_d         = ST_LDWB;
          end
          OP_LDI, OP_STI: begin
            ctrl_o.mem_en   = 1'b1;
            ctrl_o.addr_sel = ADDR_EA;
            state_d         = ST_IND;
          end
          OP_ST, OP_STR: begin
            ctrl_o.mem_en   = 1'b1;
            ctrl_o.mem_we   = 1'b1;
            ctrl_o.addr_sel = ADDR_EA;
            ctrl_o.commit   = 1'b1;
          end
          OP_TRAP: state_d = ST_TRAP;
          default: state_d = ST_HALT;
        endcase
      end
      ST_IND: begin
        ctrl_o.mem_en   = 1'b1;
        ctrl_o.addr_sel = ADDR_PTR;
        if (op_i == OP_STI) begin
          ctrl_o.mem_we = 1'b1;
          ctrl_o.commit = 1'b1;
          state_d       = ST_FETCH;
        end else begin
          state_d = ST_LDWB;
        end
      end
      ST_LDWB: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wb_sel = WB_MEM;
        ctrl_o.cc_we  = 1'b1;
        ctrl_o.commit = 1'b1;
        state_d       = ST_FETCH;
      end
      ST_TRAP: begin
        ctrl_o.trap_req = 1'b1;
        if (trap_done_i) begin
          ctrl_o.commit = 1'b1;
          state_d       = ST_FETCH;
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r10_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT |=> state_q == ST_HALT);

  a_r9_trap_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRAP && !trap_done_i) |=> state_q == ST_TRAP);
endmodule

// File: rtl/lsc16_core.sv
module lsc16_core
  import lsc16_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter logic [DATA_W-1:0] RESET_PC = 16'h3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              trap_req_o,
  output logic [7:0]        trap_vec_o,
  input  logic              trap_done_i,
  output logic              illegal_o,
  output logic              commit_o,
  output logic              commit_we_o,
  output logic [IDX_W-1:0]  commit_rd_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [2:0]        cc_o
);
  localparam logic [IDX_W-1:0] LINK_REG = IDX_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] pc_q, ir_q;
  logic [2:0]        cc_q, cc_d;
  ctrl_t             ctrl;
  state_e            state;
  opcode_e           op;

  logic [IDX_W-1:0]  rb_idx, rf_waddr;
  logic [DATA_W-1:0] rf_a, rf_b, alu_b, alu_y, imm5;
  logic [DATA_W-1:0] ea, rel, call_tgt, wb_data;

  logic              commit_q, commit_we_q;
  logic [IDX_W-1:0]  commit_rd_q;
  logic [DATA_W-1:0] commit_data_q;

  assign op   = opcode_e'(ir_q[DATA_W-1 -: 4]);
  assign imm5 = {{(DATA_W-5){ir_q[4]}}, ir_q[4:0]};

  lsc16_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .nzp_i       (ir_q[11:9]),
    .cc_i        (cc_q),
    .trap_done_i (trap_done_i),
    .ctrl_o      (ctrl),
    .state_o     (state)
  );

  // stores read their data register through port b
  assign rb_idx   = (op == OP_ST || op == OP_STR || op == OP_STI) ? ir_q[11:9] : ir_q[2:0];
  assign rf_waddr = ctrl.wb_link ? LINK_REG : ir_q[11:9];

  lsc16_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl.rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (wb_data),
    .raddr_a_i (ir_q[8:6]),
    .raddr_b_i (rb_idx),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b)
  );

  assign alu_b = ir_q[5] ? imm5 : rf_b;

  lsc16_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (op),
    .a_i  (rf_a),
    .b_i  (alu_b),
    .y_o  (alu_y)
  );

  lsc16_agu #(.DATA_W(DATA_W)) u_agu (
    .pc_i   (pc_q),
    .ir_i   (ir_q),
    .base_i (rf_a),
    .ea_o   (ea),
    .rel_o  (rel),
    .call_o (call_tgt)
  );

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  wb_data = mem_rdata_i;
      WB_PC:   wb_data = pc_q;
      WB_EA:   wb_data = ea;
      default: wb_data = alu_y;
    endcase
  end

  always_comb begin
    if (wb_data[DATA_W-1])  cc_d = CC_N;
    else if (wb_data == '0) cc_d = CC_Z;
    else                    cc_d = CC_P;
  end

  always_comb begin
    case (ctrl.addr_sel)
      ADDR_EA:  mem_addr_o = ea;
      ADDR_PTR: mem_addr_o = mem_rdata_i;
      default:  mem_addr_o = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= RESET_PC;
      ir_q <= '0;
      cc_q <= CC_Z;
    end else begin
      if (ctrl.ir_load) ir_q <= mem_rdata_i;
      if (ctrl.cc_we)   cc_q <= cc_d;
      if (ctrl.pc_inc) pc_q <= pc_q + 1'b1;
      else if (ctrl.pc_load) begin
        case (ctrl.pc_src)
          PCS_CALL: pc_q <= call_tgt;
          PCS_REG:  pc_q <= rf_a;
          default:  pc_q <= rel;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q      <= 1'b0;
      commit_we_q   <= 1'b0;
      commit_rd_q   <= '0;
      commit_data_q <= '0;
    end else begin
      commit_q      <= ctrl.commit;
      commit_we_q   <= ctrl.commit & ctrl.rf_we;
      commit_rd_q   <= rf_waddr;
      commit_data_q <= wb_data;
    end
  end

  assign mem_en_o      = ctrl.mem_en;
  assign mem_we_o      = ctrl.mem_we;
  assign mem_wdata_o   = rf_b;
  assign trap_req_o    = ctrl.trap_req;
  assign trap_vec_o    = ir_q[7:0];
  assign illegal_o     = (state == ST_HALT);
  assign commit_o      = commit_q;
  assign commit_we_o   = commit_we_q;
  assign commit_rd_o   = commit_rd_q;
  assign commit_data_o = commit_data_q;
  assign pc_o          = pc_q;
  assign cc_o          = cc_q;

  a_r11_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_DECODE |-> pc_q == $past(pc_q) + 1'b1);

  a_r3_cc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && (op == OP_ST || op == OP_STR || op == OP_BR ||
                          op == OP_JMP || op == OP_JSR)) |=> $stable(cc_q));

  a_r10_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_en_o && !commit_o);

  a_r9_vec_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_o && !trap_done_i) |=> trap_req_o && $stable(trap_vec_o));
endmodule

// File: tb/test_lsc16_core.sv
module test_lsc16_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_en_o, mem_we_o;
  logic [15:0] mem_addr_o, mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;
  logic        trap_req_o;
  logic [7:0]  trap_vec_o;
  logic        trap_done_i = 1'b0;
  logic        illegal_o, commit_o, commit_we_o;
  logic [2:0]  commit_rd_o;
  logic [15:0] commit_data_o, pc_o;
  logic [2:0]  cc_o;

  always #2 clk_i = ~clk_i;

  lsc16_core i_lsc16_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .trap_req_o(trap_req_o), .trap_vec_o(trap_vec_o), .trap_done_i(trap_done_i),
    .illegal_o(illegal_o), .commit_o(commit_o), .commit_we_o(commit_we_o),
    .commit_rd_o(commit_rd_o), .commit_data_o(commit_data_o),
    .pc_o(pc_o), .cc_o(cc_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory seen by the core
  logic [15:0] b_mem [logic [15:0]];
  logic [15:0] last_wa = '0, last_wd = '0;
  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) begin
        b_mem[mem_addr_o] = mem_wdata_o;
        last_wa <= mem_addr_o;
        last_wd <= mem_wdata_o;
      end else begin
        mem_rdata_i <= b_mem.exists(mem_addr_o) ? b_mem[mem_addr_o] : 16'h0;
      end
    end
  end

  // instruction-level reference model
  logic [15:0] m_r [8];
  logic [15:0] m_pc;
  logic [2:0]  m_cc;
  logic [15:0] m_mem [logic [15:0]];

  function automatic logic [15:0] mrd(logic [15:0] a);
    return m_mem.exists(a) ? m_mem[a] : 16'h0;
  endfunction

  function automatic logic [15:0] sx(logic [15:0] v, int bits);
    logic [15:0] r = v;
    for (int i = bits; i < 16; i++) r[i] = v[bits-1];
    return r;
  endfunction

  function automatic logic [2:0] ccof(logic [15:0] v);
    return v[15] ? 3'b100 : (v == 16'h0 ? 3'b010 : 3'b001);
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) m_r[i] = '0;
    m_pc = 16'h3000;
    m_cc = 3'b010;
    m_mem.delete();
    b_mem.delete();
  endtask

  task automatic m_step(output bit we, output logic [2:0] rd, output logic [15:0] wd,
                        output bit st, output logic [15:0] sa, output logic [15:0] sd,
                        output string req);
    logic [15:0] ins, b, v, t;
    logic [3:0] op;
    logic [2:0] dr, sr;
    ins = mrd(m_pc);
    m_pc = m_pc + 1;
    op = ins[15:12]; dr = ins[11:9]; sr = ins[8:6];
    we = 0; rd = dr; wd = '0; st = 0; sa = '0; sd = '0; req = "R11";
    case (op)
      4'd1, 4'd5: begin
        b = ins[5] ? sx({11'h0, ins[4:0]}, 5) : m_r[ins[2:0]];
        v = (op == 4'd1) ? m_r[sr] + b : m_r[sr] & b;
        we = 1; wd = v; req = "R2 R3";
      end
      4'd9: begin we = 1; wd = ~m_r[sr]; req = "R2 R3"; end
      4'd0: begin
        if ((ins[11] && m_cc[2]) || (ins[10] && m_cc[1]) || (ins[9] && m_cc[0]))
          m_pc = m_pc + sx({7'h0, ins[8:0]}, 9);
        req = "R4";
      end
      4'd2: begin we = 1; wd = mrd(m_pc + sx({7'h0, ins[8:0]}, 9)); req = "R6 R3"; end
      4'd3: begin st = 1; sa = m_pc + sx({7'h0, ins[8:0]}, 9); sd = m_r[dr]; req = "R6"; end
      4'd14: begin we = 1; wd = m_pc + sx({7'h0, ins[8:0]}, 9); req = "R6 R3"; end
      4'd6: begin we = 1; wd = mrd(m_r[sr] + sx({10'h0, ins[5:0]}, 6)); req = "R7"; end
      4'd7: begin st = 1; sa = m_r[sr] + sx({10'h0, ins[5:0]}, 6); sd = m_r[dr]; req = "R7"; end
      4'd10: begin we = 1; wd = mrd(mrd(m_pc + sx({7'h0, ins[8:0]}, 9))); req = "R8"; end
      4'd11: begin st = 1; sa = mrd(m_pc + sx({7'h0, ins[8:0]}, 9)); sd = m_r[dr]; req = "R8"; end
      4'd4: begin
        t = ins[11] ? m_pc + sx({5'h0, ins[10:0]}, 11) : m_r[sr];
        we = 1; rd = 3'd7; wd = m_pc; m_r[7] = m_pc; m_pc = t; req = "R5";
      end
      4'd12: begin m_pc = m_r[sr]; req = "R5"; end
      4'd15: req = "R9";
      default: req = "R10";
    endcase
    if (we && op != 4'd4) begin m_r[rd] = wd; m_cc = ccof(wd); end
    if (st) m_mem[sa] = sd;
  endtask

  // retire monitor
  bit run = 0, ill_seen = 0, have_last = 0;
  int last_c = 0;
  initial forever begin
    @(negedge clk_i);
    if (run) begin
      if (commit_o) begin
        bit e_we, e_st;
        logic [2:0] e_rd;
        logic [15:0] e_wd, e_sa, e_sd, ins;
        string req;
        int exp_d;
        ins = mrd(m_pc);
        m_step(e_we, e_rd, e_wd, e_st, e_sa, e_sd, req);
        chk(pc_o == m_pc && cc_o == m_cc && commit_we_o == e_we &&
            (!e_we || (commit_rd_o == e_rd && commit_data_o == e_wd)),
            {req, " R11 retire"},
            {25'h0, pc_o, cc_o, commit_we_o, commit_rd_o, commit_data_o},
            {25'h0, m_pc, m_cc, e_we, e_rd, e_wd});
        if (e_st)
          chk(last_wa == e_sa && last_wd == e_sd, {req, " store"},
              {32'h0, last_wa, last_wd}, {32'h0, e_sa, e_sd});
        case (ins[15:12])
          4'd2, 4'd6, 4'd11: exp_d = 4;
          4'd10:             exp_d = 5;
          default:           exp_d = 3;
        endcase
        if (have_last && ins[15:12] != 4'd15)
          chk(cyc - last_c == exp_d, "R11 spacing", 64'(cyc - last_c), 64'(exp_d));
        last_c = cyc;
        have_last = 1;
      end
      if (illegal_o && !ill_seen) begin
        logic [15:0] ins;
        ins = mrd(m_pc);
        chk(ins[15:12] == 4'd8 || ins[15:12] == 4'd13, "R10 halt opcode",
            64'(ins[15:12]), 64'd8);
        ill_seen = 1;
      end
      if (!illegal_o && ill_seen) chk(0, "R10 sticky", 64'd0, 64'd1);
    end
  end

  // trap service: vector 0x25 answers at once, others after three cycles
  int tcnt = 0;
  initial forever begin
    @(negedge clk_i);
    if (trap_done_i) begin
      trap_done_i = 1'b0;
      tcnt = 0;
    end else if (trap_req_o) begin
      logic [15:0] ins;
      int lat;
      ins = mrd(m_pc);
      if (tcnt == 0) chk(trap_vec_o == ins[7:0], "R9 vector", 64'(trap_vec_o), 64'(ins[7:0]));
      lat = (trap_vec_o == 8'h25) ? 0 : 3;
      if (tcnt >= lat) trap_done_i = 1'b1;
      else tcnt++;
    end
  end

  // program construction
  int pa = 0;
  task automatic put(int a, logic [15:0] w);
    b_mem[16'(a)] = w;
    m_mem[16'(a)] = w;
  endtask
  task automatic em(logic [15:0] w);
    put(pa, w);
    pa++;
  endtask
  function automatic logic [15:0] f_rrr(int op, int d, int s1, int s2);
    return {op[3:0], d[2:0], s1[2:0], 3'b000, s2[2:0]};
  endfunction
  function automatic logic [15:0] f_rri(int op, int d, int s1, int imm);
    return {op[3:0], d[2:0], s1[2:0], 1'b1, imm[4:0]};
  endfunction
  function automatic logic [15:0] f_o9(int op, int d, int off);
    return {op[3:0], d[2:0], off[8:0]};
  endfunction
  function automatic logic [15:0] f_o6(int op, int d, int b, int off);
    return {op[3:0], d[2:0], b[2:0], off[5:0]};
  endfunction
  function automatic int rel(int tgt);
    return tgt - (pa + 1);
  endfunction

  localparam int DB = 'h3080;

  task automatic load_prog1();
    pa = 'h3000;
    em(f_rri(1, 1, 0, 5));
    em(f_rri(1, 2, 0, -3));
    em(f_rrr(1, 3, 1, 2));
    em(f_rri(5, 4, 3, 0));
    em(f_rrr(9, 5, 2, 63));
    em(f_rrr(5, 6, 1, 5));
    em(f_o9(0, 3'b010, 1));
    em(f_rri(1, 6, 0, 15));
    em(f_o9(0, 3'b100, 1));
    em(f_rri(1, 6, 6, -16));
    em(f_o9(0, 3'b001, 1));
    em(f_o9(2, 7, rel(DB)));
    em(f_o9(2, 0, rel(DB + 1)));
    em(f_o9(14, 4, rel(DB)));
    em(f_o6(6, 5, 4, 1));
    em(f_o6(6, 5, 4, 2));
    em(f_o6(7, 2, 4, 5));
    em(f_o9(3, 3, rel(DB + 4)));
    em(f_o6(6, 6, 4, 5));
    em(f_o9(10, 0, rel(DB + 3)));
    em(f_o9(11, 1, rel(DB + 3)));
    em(f_o9(10, 3, rel(DB + 3)));
    em({4'd4, 1'b1, 11'd1});
    em(f_o9(0, 3'b111, 1));
    em({4'd12, 3'd0, 3'd7, 6'd0});
    em(f_o9(14, 4, 2));
    em({4'd4, 3'd0, 3'd4, 6'd0});
    em(f_o9(0, 3'b111, 1));
    em({4'd12, 3'd0, 3'd7, 6'd0});
    em({4'd15, 4'd0, 8'h25});
    em({4'd15, 4'd0, 8'h21});
    em(f_rrr(1, 1, 1, 1));
    em({4'd8, 12'h0});
    put(DB,     16'h8001);
    put(DB + 1, 16'h0000);
    put(DB + 2, 16'h1234);
    put(DB + 3, 16'h3090);
    put('h3090, 16'h7fff);
  endtask

  task automatic load_prog2();
    pa = 'h3000;
    em(f_rri(1, 1, 0, 3));
    em(f_rri(1, 1, 1, -1));
    em(f_o9(0, 3'b001, -2));
    em(f_o9(0, 3'b100, 1));
    em(f_o9(0, 3'b010, 1));
    em(f_rri(1, 2, 0, 1));
    em(f_o9(14, 3, 2));
    em({4'd12, 3'd0, 3'd3, 6'd0});
    em(f_rri(1, 2, 0, 7));
    em({4'd15, 4'd0, 8'h30});
    em(f_rri(1, 2, 0, -1));
    em({4'd13, 12'h0});
  endtask

  task automatic run_to_halt();
    int n = 0;
    while (!ill_seen && n < 20000) begin
      @(negedge clk_i);
      n++;
    end
    chk(ill_seen, "R10 halt reached", 64'(ill_seen), 64'd1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      chk(illegal_o && !mem_en_o && !commit_o, "R10 quiet",
          {61'h0, illegal_o, mem_en_o, commit_o}, 64'h4);
    end
  endtask

  task automatic start(bit second);
    run = 0; ill_seen = 0; have_last = 0;
    rst_ni = 1'b0;
    m_reset();
    if (second) load_prog2(); else load_prog1();
    repeat (2) @(negedge clk_i);
    chk(pc_o == 16'h3000 && cc_o == 3'b010 && !illegal_o && !commit_o && !trap_req_o,
        "R1 reset state", {45'h0, pc_o, cc_o}, {45'h0, 16'h3000, 3'b010});
    chk(mem_en_o && !mem_we_o && mem_addr_o == 16'h3000, "R1 first fetch",
        {46'h0, mem_en_o, mem_we_o, mem_addr_o}, {46'h0, 2'b10, 16'h3000});
    rst_ni = 1'b1;
    run = 1;
    @(negedge clk_i);
    chk(pc_o == 16'h3001 && !commit_o, "R1 after release", 64'(pc_o), 64'h3001);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL R11 watchdog: actual timeout expected finish");
    finish_sim();
  end

  initial begin
    start(0);
    run_to_halt();
    start(1);
    run_to_halt();
    finish_sim();
  end
endmodule